// File: doc/BRIEF.md
# Receive Preamble Validator and Address Filter

This block sits at the front of a serial receiver. It watches single bits, each qualified by a bit-valid strobe, while a frame-active input is high. First it checks that the preamble alternates. A pair of equal bits ends that check. Two ones form the start delimiter, and the address starts on the next bit. Two zeros mark a broken preamble, and the rest of the frame is then ignored.

After the delimiter the block gathers an 8-bit or 16-bit destination address. It compares the address with a programmed station address, and any bit set in a mask is not compared. An address made of all ones is always taken. The block gives its verdict as a one-cycle accept or reject strobe. Accepted frames then hold a level flag for the rest of the frame. The gathered address is shown on an output bus whatever the verdict, so that later stages can read it.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, both decision strobes and the accepted flag are low and the address output is all zeros.
- R2: If two 0 bits arrive in a row before the start delimiter, the frame is ignored. No strobe fires and the accepted flag stays low until frame-active falls, even if ones or a full address follow.
- R3: Two 1 bits in a row end the preamble, and the next valid bit is address bit 0. An empty preamble, where the first two bits are ones, is legal. Cycles in which the bit-valid strobe is low are skipped.
- R4: When wideAddr is 1 the address is 16 bits long, and when it is 0 it is 8 bits long. The k-th received address bit appears on addrOut[k]. In 8-bit mode addrOut[15:8] reads 0, and the station and mask bits 15:8 are not used.
- R5: If every unmasked address bit equals the matching station bit, acceptStb is high for exactly the one cycle after the clock edge that took the last address bit. From the next cycle, frameAccepted stays high until frame-active falls.
- R6: If any unmasked address bit differs from the station bit, and the address is not all ones, rejectStb pulses in that same cycle. frameAccepted stays low, and the rest of the frame causes no more strobes.
- R7: A mask bit of 1 makes that address position match whatever its value. With a full mask every address is accepted.
- R8: An address with all of its active-length bits equal to 1 is accepted, whatever the station address and mask.
- R9: Whenever frame-active is low at a clock edge, the block goes back to preamble hunting. From the next cycle no strobe fires and frameAccepted is low, and the next frame is judged afresh.
- R10: Each frame gets at most one decision, and acceptStb and rejectStb are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameActive | input | 1 | High while a frame is on the line |
| bitValid | input | 1 | Marks bitIn as a new received bit this cycle |
| bitIn | input | 1 | Received serial bit |
| wideAddr | input | 1 | 1 for a 16-bit address, 0 for an 8-bit address |
| stationAddr | input | 16 | Programmed station address, bit 0 compared first |
| addrMask | input | 16 | 1 marks a don't-care address bit |
| acceptStb | output | 1 | One-cycle pulse when the frame is accepted |
| rejectStb | output | 1 | One-cycle pulse when the frame is rejected |
| frameAccepted | output | 1 | Held high from accept until the frame ends |
| addrOut | output | 16 | Address bits gathered in the last frame |

## Verification
A bit counter that slips shows up as a decision strobe one or more bits early or late, and as a shifted pattern on addrOut in the very cycle the strobe is due. A wrong hunting state shows up within two bits of the preamble: a broken preamble would still produce a verdict, or a good one would never produce one. A state that fails to clear when frame-active falls leaves frameAccepted high, or fires a strobe, in the cycle after the edge that should have cleared it.

// File: rtl/rx_addr_pkg.sv
package rx_addr_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_ADDR,
    ST_DECIDE,
    ST_KEEP,
    ST_DROP
  } rxState_e;

  // Strobes from the control FSM to the address datapath.
  typedef struct packed {
    logic clrAddr;
    logic shiftBit;
  } dpCtrl_t;

endpackage

// File: rtl/rx_addr_dpath.sv
module rx_addr_dpath
  import rx_addr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              bitIn,
  input  logic              wideAddr,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic [ADDR_W-1:0] addrMask,
  output logic              lastBit,
  output logic              addrMatch,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_W - 1);

  logic [CNT_W-1:0]  bitIdx;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] lenMask;

  // Positions below the narrow length are always live; the rest only in wide mode.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_len
    if (i < NARROW_W) begin : g_low
      assign lenMask[i] = 1'b1;
    end else begin : g_high
      assign lenMask[i] = wideAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx  <= '0;
      addrReg <= '0;
    end else if (ctrl.clrAddr) begin
      bitIdx  <= '0;
      addrReg <= '0;
    end else if (ctrl.shiftBit) begin
      addrReg[bitIdx] <= bitIn;
      bitIdx          <= bitIdx + 1'b1;
    end
  end

  logic allOnes;
  logic exactHit;

  always_comb begin
    lastBit   = (bitIdx == (wideAddr ? WIDE_LAST : NARROW_LAST));
    allOnes   = &(addrReg | ~lenMask);
    exactHit  = ~|((addrReg ^ stationAddr) & ~addrMask & lenMask);
    addrMatch = allOnes | exactHit;
  end

  assign addrOut = addrReg;

endmodule

// File: rtl/rx_addr_ctrl.sv
module rx_addr_ctrl
  import rx_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameActive,
  input  logic    bitValid,
  input  logic    bitIn,
  input  logic    lastBit,
  input  logic    addrMatch,
  output dpCtrl_t ctrl,
  output logic    acceptStb,
  output logic    rejectStb,
  output logic    frameAccepted
);

  rxState_e state, stateNxt;
  logic     prevBit, prevBitNxt;
  logic     havePrev, havePrevNxt;

  always_comb begin
    stateNxt      = state;
    prevBitNxt    = prevBit;
    havePrevNxt   = havePrev;
    ctrl.clrAddr  = 1'b0;
    ctrl.shiftBit = 1'b0;

    if (!frameActive) begin
      stateNxt    = ST_HUNT;
      havePrevNxt = 1'b0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (bitValid) begin
            if (havePrev && (prevBit == bitIn)) begin
              if (bitIn) begin
                stateNxt     = ST_ADDR;
                ctrl.clrAddr = 1'b1;
              end else begin
                stateNxt = ST_DROP;
              end
              havePrevNxt = 1'b0;
            end else begin
              prevBitNxt  = bitIn;
              havePrevNxt = 1'b1;
            end
          end
        end
        ST_ADDR: begin
          if (bitValid) begin
            ctrl.shiftBit = 1'b1;
            if (lastBit) stateNxt = ST_DECIDE;
          end
        end
        ST_DECIDE: stateNxt = addrMatch ? ST_KEEP : ST_DROP;
        ST_KEEP:   stateNxt = ST_KEEP;
        ST_DROP:   stateNxt = ST_DROP;
        default:   stateNxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      prevBit  <= 1'b0;
      havePrev <= 1'b0;
    end else begin
      state    <= stateNxt;
      prevBit  <= prevBitNxt;
      havePrev <= havePrevNxt;
    end
  end

  assign acceptStb     = (state == ST_DECIDE) && frameActive && addrMatch;
  assign rejectStb     = (state == ST_DECIDE) && frameActive && !addrMatch;
  assign frameAccepted = (state == ST_KEEP);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameActive,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic              wideAddr,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic [ADDR_W-1:0] addrMask,
  output logic              acceptStb,
  output logic              rejectStb,
  output logic              frameAccepted,
  output logic [ADDR_W-1:0] addrOut
);

  dpCtrl_t dpCtrl;
  logic    lastBit;
  logic    addrMatch;

  rx_addr_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameActive  (frameActive),
    .bitValid     (bitValid),
    .bitIn        (bitIn),
    .lastBit      (lastBit),
    .addrMatch    (addrMatch),
    .ctrl         (dpCtrl),
    .acceptStb    (acceptStb),
    .rejectStb    (rejectStb),
    .frameAccepted(frameAccepted)
  );

  rx_addr_dpath #(
    .ADDR_W  (ADDR_W),
    .NARROW_W(NARROW_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (dpCtrl),
    .bitIn      (bitIn),
    .wideAddr   (wideAddr),
    .stationAddr(stationAddr),
    .addrMask   (addrMask),
    .lastBit    (lastBit),
    .addrMatch  (addrMatch),
    .addrOut    (addrOut)
  );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic clk,
  input logic rstN,
  input logic frameActive,
  input logic acceptStb,
  input logic rejectStb,
  input logic frameAccepted
);

  assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptStb && rejectStb));

  assert_accept_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |=> !acceptStb && frameAccepted);

  assert_reject_holds_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    rejectStb |=> !frameAccepted && !rejectStb && !acceptStb);

  assert_frame_end_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |=> !frameAccepted && !acceptStb && !rejectStb);

  assert_no_verdict_while_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameAccepted |-> !acceptStb && !rejectStb);

endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .frameActive  (frameActive),
  .acceptStb    (acceptStb),
  .rejectStb    (rejectStb),
  .frameAccepted(frameAccepted)
);

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameActive = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic        wideAddr = 1'b0;
  logic [15:0] stationAddr = '0;
  logic [15:0] addrMask = '0;
  logic        acceptStb, rejectStb, frameAccepted;
  logic [15:0] addrOut;

  int checks = 0;
  int errors = 0;
  int accN = 0;
  int rejN = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .frameActive(frameActive), .bitValid(bitValid),
    .bitIn(bitIn), .wideAddr(wideAddr), .stationAddr(stationAddr),
    .addrMask(addrMask), .acceptStb(acceptStb), .rejectStb(rejectStb),
    .frameAccepted(frameAccepted), .addrOut(addrOut)
  );

  always @(posedge clk) begin
    if (acceptStb) accN++;
    if (rejectStb) rejN++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); bitValid = 1'b0; bitIn = ~b;
    end
    @(negedge clk); bitIn = b; bitValid = 1'b1;
    @(posedge clk); #1; bitValid = 1'b0;
  endtask

  task automatic startFrame();
    @(negedge clk); frameActive = 1'b1; accN = 0; rejN = 0;
  endtask

  task automatic endFrame(input string tag);
    @(negedge clk); frameActive = 1'b0;
    @(posedge clk); #1;
    check(!frameAccepted && !acceptStb && !rejectStb, tag, {31'd0, frameAccepted}, 0);
  endtask

  task automatic sendPreamble();
    for (int i = 0; i < 6; i++) sendBit(i % 2 == 0, 0);
    sendBit(1'b1, 0); sendBit(1'b1, 0);
  endtask

  // Sends the address bit 0 first, checks the verdict cycle, then 8 payload bits.
  task automatic sendAddrAndCheck(input logic [15:0] a, input logic expAcc,
                                  input int gap, input string tag);
    int n;
    logic [15:0] expOut;
    n = wideAddr ? 16 : 8;
    expOut = wideAddr ? a : (a & 16'h00FF);
    for (int k = 0; k < n; k++) sendBit(a[k], gap);
    check(acceptStb == expAcc && rejectStb == !expAcc, {tag, " strobe"},
          {30'd0, acceptStb, rejectStb}, {30'd0, expAcc, !expAcc});
    check(addrOut == expOut, {tag, " addrOut R4"}, {16'd0, addrOut}, {16'd0, expOut});
    for (int k = 0; k < 8; k++) sendBit(k < 4, 0);
    check(frameAccepted == expAcc && accN == int'(expAcc) && rejN == int'(!expAcc),
          {tag, " held R10"}, {frameAccepted, 7'd0, 8'(accN), 8'(rejN), 8'd0},
          {expAcc, 7'd0, 8'(expAcc), 8'(!expAcc), 8'd0});
  endtask

  // {wide, station, mask, address, expected accept}
  localparam logic [49:0] VEC [10] = '{
    {1'b0, 16'h00A5, 16'h0000, 16'h00A5, 1'b1},  // R5 exact match
    {1'b0, 16'h00A5, 16'h0000, 16'h00A4, 1'b0},  // R6 bit 0 differs
    {1'b0, 16'h00A5, 16'h00F0, 16'h0035, 1'b1},  // R7 high nibble masked
    {1'b0, 16'h0012, 16'h0000, 16'h00FF, 1'b1},  // R8 all ones narrow
    {1'b1, 16'hBEEF, 16'h0000, 16'hBEEF, 1'b1},  // R4 wide match
    {1'b1, 16'hBEEF, 16'h0000, 16'h3EEF, 1'b0},  // R6 last bit differs
    {1'b1, 16'h1234, 16'hFFFF, 16'h0000, 1'b1},  // R7 full mask
    {1'b1, 16'h0000, 16'h0000, 16'hFFFF, 1'b1},  // R8 all ones wide
    {1'b1, 16'h0000, 16'h0000, 16'h00FF, 1'b0},  // R8 not all ones in wide mode
    {1'b0, 16'h5511, 16'h0000, 16'hFF11, 1'b1}   // R4 upper bits unused
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!acceptStb && !rejectStb && !frameAccepted && addrOut == 0, "R1 reset",
          {13'd0, acceptStb, rejectStb, frameAccepted, addrOut}, 0);
    @(negedge clk); rstN = 1'b1;

    for (int v = 0; v < 10; v++) begin
      wideAddr    = VEC[v][49];
      stationAddr = VEC[v][48:33];
      addrMask    = VEC[v][32:17];
      startFrame();
      sendPreamble();
      sendAddrAndCheck(VEC[v][16:1], VEC[v][0], 0, $sformatf("vec%0d R5 R6", v));
      endFrame("R9 end");
    end

    // R2: double zero in the preamble, then a delimiter and an all-ones address.
    wideAddr = 1'b0; stationAddr = 16'h00A5; addrMask = '0;
    startFrame();
    sendBit(1'b1, 0); sendBit(1'b0, 0); sendBit(1'b0, 0);
    sendBit(1'b1, 0); sendBit(1'b1, 0);
    for (int k = 0; k < 12; k++) sendBit(1'b1, 0);
    check(accN == 0 && rejN == 0 && !frameAccepted, "R2 bad preamble",
          {16'(accN), 15'(rejN), frameAccepted}, 0);
    endFrame("R9 after R2");

    // R3: empty preamble, address starts right after the two ones.
    startFrame();
    sendBit(1'b1, 0); sendBit(1'b1, 0);
    sendAddrAndCheck(16'h00A5, 1'b1, 0, "R3 empty preamble");
    endFrame("R9 after R3");

    // R3: gaps in the bit strobe are skipped.
    startFrame();
    sendBit(1'b0, 2); sendBit(1'b1, 1); sendBit(1'b1, 3);
    sendAddrAndCheck(16'h00A5, 1'b1, 2, "R3 gaps");
    endFrame("R9 after gaps");

    // R9: frame drops in the middle of the address, then a new frame.
    startFrame();
    sendPreamble();
    for (int k = 0; k < 4; k++) sendBit(1'b1, 0);
    @(negedge clk); frameActive = 1'b0;
    repeat (12) begin @(posedge clk); #1; end
    check(accN == 0 && rejN == 0 && !frameAccepted, "R9 mid-address drop",
          {16'(accN), 15'(rejN), frameAccepted}, 0);
    startFrame();
    sendPreamble();
    sendAddrAndCheck(16'h005A, 1'b0, 0, "R9 fresh frame");
    endFrame("R9 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule